// File: doc/BRIEF.md
# Streaming Hash Block Aggregator

This block feeds a hash core that works on 64-byte blocks and takes its input as 32-bit words. Message bytes reach it in requests. A request states its byte length and whether it is the last one of the message. The block keeps up to 63 bytes between requests. For each request it forwards to the core only as much of the kept bytes plus the new bytes as the request mode allows. The bytes that are left over become the new residual.

An update request forwards only whole 64-byte blocks. A final request forwards everything down to a 4-byte boundary, which leaves 0 to 3 bytes for a padding stage downstream. The block counts the bytes it has handed to the core. The context is the total count and the residual bytes. It can be read out at any idle moment and loaded back later, so a half-hashed message can be suspended and resumed.

Bytes enter one per cycle over a valid/ready stream. Residual bytes are always forwarded ahead of the request's own bytes. Words leave over a valid/ready stream with a registered output.

Top module: `stream_hash_aggregator`

## Requirements
- R1: After reset the block is idle (`req_ready`=1), `out_valid`=0, `in_ready`=0, `req_err`=0 and `ctx_total`=0.
- R2: An update request for which residual length plus `req_len` is below 64 forwards no word. All of its bytes are appended to the residual, whose length becomes the old length plus `req_len`.
- R3: An update request forwards exactly the largest multiple of 64 that does not exceed residual length plus `req_len` (counted across residual and new bytes). The remaining bytes, always fewer than 64, become the residual in order. For example, two 60-byte updates from empty leave a 56-byte residual.
- R4: A final request forwards the largest multiple of 4 that does not exceed residual length plus `req_len`. The remaining 0 to 3 bytes stay as the residual, including the case where fewer bytes are forwarded than were buffered.
- R5: Forwarded bytes are the residual bytes in buffer order followed by the request bytes in arrival order. They are packed little-endian: the earliest byte goes in `out_word[7:0]` and the fourth in `out_word[31:24]`.
- R6: The forwarded count grows by 4 for each accepted output word. When idle, `ctx_total` equals the forwarded count plus the residual length, and `ctx_resid_len` equals the residual length.
- R7: An idle `ctx_load` pulse sets the residual length to `ctx_load_total[5:0]` and the forwarded count to `ctx_load_total` with its low 6 bits cleared. `ctx_wr_en` writes residual byte `ctx_wr_idx`, and `ctx_rd_byte` shows residual byte `ctx_rd_idx`.
- R8: A request with `req_len` greater than 2^32-1 minus the residual length is refused. `req_err` is high for exactly the next cycle, the block stays idle and `ctx_total` and the residual are unchanged.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` holds its value and `out_valid` stays high.
- R10: `req_ready` is low from request acceptance until all words have been accepted. `in_ready` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_final | input | 1 | Request is the last of the message |
| req_len | input | 32 | Request length in bytes |
| req_ready | output | 1 | Block idle, request or context access allowed |
| req_err | output | 1 | One-cycle pulse on a refused request |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Input byte taken this cycle |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Packed output word |
| out_ready | input | 1 | Core accepts the word |
| ctx_total | output | 64 | Forwarded count plus residual length |
| ctx_resid_len | output | 6 | Residual length |
| ctx_rd_idx | input | 6 | Residual byte read index |
| ctx_rd_byte | output | 8 | Residual byte at read index |
| ctx_load | input | 1 | Load context total (idle only) |
| ctx_load_total | input | 64 | Context total to load |
| ctx_wr_en | input | 1 | Residual byte write (idle only) |
| ctx_wr_idx | input | 6 | Residual byte write index |
| ctx_wr_byte | input | 8 | Residual byte write data |

## Verification
The assertions assume a producer that issues a request only while `req_ready` is high. The producer must then supply exactly `req_len` bytes and must not pulse `ctx_load` or `ctx_wr_en` while a request runs. The bench drives requests and context loads only after it has seen the block idle. It feeds exactly the byte count it announced and throttles both streams at random, so backpressure and input gaps occur inside every run. Context writes touch only indices below the loaded residual length.

// File: rtl/hagg_pkg.sv
package hagg_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {AGG_IDLE, AGG_RUN} agg_state_e;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/hagg_limit.sv
module hagg_limit #(
  parameter int LEN_W     = 32,
  parameter int IDX_W     = 6,
  parameter int BLK_BYTES = 64,
  parameter int WORD_B    = 4,
  localparam int POS_W    = LEN_W + 1
) (
  input  logic [IDX_W-1:0] resid_len,
  input  logic [LEN_W-1:0] req_len,
  input  logic             is_final,
  output logic [POS_W-1:0] total,
  output logic [POS_W-1:0] fwd_lim,
  output logic [POS_W-1:0] start_pos,
  output logic             overflow
);
  localparam logic [POS_W-1:0] BLK_MASK  = ~(POS_W'(BLK_BYTES - 1));
  localparam logic [POS_W-1:0] WORD_MASK = ~(POS_W'(WORD_B - 1));

  always_comb begin
    total     = {1'b0, req_len} + POS_W'(resid_len);
    overflow  = total[LEN_W];
    fwd_lim   = total & (is_final ? WORD_MASK : BLK_MASK);
    // nothing to forward: skip the residual bytes already in place
    start_pos = (fwd_lim == '0) ? POS_W'(resid_len) : '0;
  end
endmodule

// File: rtl/hagg_resbuf.sv
module hagg_resbuf
  import hagg_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  byte_t            wdata,
  input  logic [IDX_W-1:0] ra_idx,
  output byte_t            ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output byte_t            rb_data
);
  byte_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (ent_en) mem[g] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/hagg_packer.sv
module hagg_packer
  import hagg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  byte_t       byte_in,
  output logic        byte_ok,
  output logic        word_vld,
  output logic [31:0] word,
  input  logic        word_rdy,
  output logic        empty
);
  localparam int CW  = $clog2(WORD_BYTES);
  localparam int ACC = (WORD_BYTES - 1) * 8;

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [ACC-1:0] acc_q, acc_d;
  logic           vld_q, vld_d;
  logic [31:0]    word_q, word_d;
  logic           last;

  assign last    = (cnt_q == CW'(WORD_BYTES - 1));
  assign byte_ok = !last || !vld_q || word_rdy;

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    word_d = word_q;
    vld_d  = vld_q && !word_rdy;
    if (byte_vld && byte_ok) begin
      if (last) begin
        word_d = {byte_in, acc_q};
        vld_d  = 1'b1;
        cnt_d  = '0;
      end else begin
        acc_d[cnt_q*8 +: 8] = byte_in;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;
  assign empty    = (cnt_q == '0);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !word_rdy) |=> (vld_q && $stable(word_q)));
endmodule

// File: rtl/stream_hash_aggregator.sv
module stream_hash_aggregator
  import hagg_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int LEN_W     = 32,
  parameter int BLK_BYTES = 64,
  localparam int IDX_W    = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_final,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             req_err,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  output logic [31:0]      out_word,
  input  logic             out_ready,
  output logic [CNT_W-1:0] ctx_total,
  output logic [IDX_W-1:0] ctx_resid_len,
  input  logic [IDX_W-1:0] ctx_rd_idx,
  output logic [7:0]       ctx_rd_byte,
  input  logic             ctx_load,
  input  logic [CNT_W-1:0] ctx_load_total,
  input  logic             ctx_wr_en,
  input  logic [IDX_W-1:0] ctx_wr_idx,
  input  logic [7:0]       ctx_wr_byte
);
  localparam int POS_W = LEN_W + 1;

  agg_state_e       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d, end_q, end_d, lim_q, lim_d;
  logic [IDX_W-1:0] resid_q, resid_d;
  logic [CNT_W-1:0] fwd_q, fwd_d;
  logic             err_q, err_d;
  logic             short_q, short_d;

  logic [POS_W-1:0] lim_total, lim_fwd, lim_start, wr_off, rem;
  logic             lim_ovf;
  logic             running, pos_live, src_buf, to_pk, sink_ok, have_byte;
  logic             step, done, out_fire;
  byte_t            buf_ra, cur_byte, buf_wdata;
  logic             buf_we;
  logic [IDX_W-1:0] buf_widx;
  logic             pk_ok, pk_empty, pk_vld;

  hagg_limit #(
    .LEN_W(LEN_W), .IDX_W(IDX_W), .BLK_BYTES(BLK_BYTES), .WORD_B(WORD_BYTES)
  ) u_limit (
    .resid_len(resid_q),
    .req_len  (req_len),
    .is_final (req_final),
    .total    (lim_total),
    .fwd_lim  (lim_fwd),
    .start_pos(lim_start),
    .overflow (lim_ovf)
  );

  // byte stepping: position counts residual bytes first, then request bytes
  assign running   = (st_q == AGG_RUN);
  assign pos_live  = (pos_q != end_q);
  assign src_buf   = (pos_q < POS_W'(resid_q));
  assign to_pk     = (pos_q < lim_q);
  assign sink_ok   = to_pk ? pk_ok : 1'b1;
  assign have_byte = src_buf || in_valid;
  assign step      = running && pos_live && have_byte && sink_ok;
  assign in_ready  = running && pos_live && !src_buf && sink_ok;
  assign cur_byte  = src_buf ? buf_ra : in_byte;
  assign wr_off    = pos_q - lim_q;
  assign rem       = end_q - lim_q;
  assign pk_vld    = step && to_pk;
  assign out_fire  = out_valid && out_ready;
  assign done      = running && !pos_live && pk_empty && !out_valid;

  // buffer write port: compaction while running, context writes while idle
  always_comb begin
    if (running) begin
      buf_we    = step && !to_pk;
      buf_widx  = wr_off[IDX_W-1:0];
      buf_wdata = cur_byte;
    end else begin
      buf_we    = ctx_wr_en;
      buf_widx  = ctx_wr_idx;
      buf_wdata = ctx_wr_byte;
    end
  end

  hagg_resbuf #(.DEPTH(BLK_BYTES)) u_buf (
    .clk    (clk),
    .we     (buf_we),
    .widx   (buf_widx),
    .wdata  (buf_wdata),
    .ra_idx (pos_q[IDX_W-1:0]),
    .ra_data(buf_ra),
    .rb_idx (ctx_rd_idx),
    .rb_data(ctx_rd_byte)
  );

  hagg_packer u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(pk_vld),
    .byte_in (cur_byte),
    .byte_ok (pk_ok),
    .word_vld(out_valid),
    .word    (out_word),
    .word_rdy(out_ready),
    .empty   (pk_empty)
  );

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    end_d   = end_q;
    lim_d   = lim_q;
    resid_d = resid_q;
    fwd_d   = fwd_q;
    short_d = short_q;
    err_d   = 1'b0;
    if (out_fire) fwd_d = fwd_q + CNT_W'(WORD_BYTES);
    unique case (st_q)
      AGG_IDLE: begin
        if (ctx_load) begin
          fwd_d   = ctx_load_total & ~(CNT_W'(BLK_BYTES - 1));
          resid_d = ctx_load_total[IDX_W-1:0];
        end else if (req_valid) begin
          if (lim_ovf) begin
            err_d = 1'b1;
          end else begin
            st_d    = AGG_RUN;
            pos_d   = lim_start;
            end_d   = lim_total;
            lim_d   = lim_fwd;
            short_d = (lim_fwd == '0);
          end
        end
      end
      AGG_RUN: begin
        if (step) pos_d = pos_q + 1'b1;
        if (done) begin
          st_d    = AGG_IDLE;
          resid_d = rem[IDX_W-1:0];
          short_d = 1'b0;
        end
      end
      default: st_d = AGG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= AGG_IDLE;
      pos_q   <= '0;
      end_q   <= '0;
      lim_q   <= '0;
      resid_q <= '0;
      fwd_q   <= '0;
      err_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      end_q   <= end_d;
      lim_q   <= lim_d;
      resid_q <= resid_d;
      fwd_q   <= fwd_d;
      err_q   <= err_d;
      short_q <= short_d;
    end
  end

  assign req_ready     = !running;
  assign req_err       = err_q;
  assign ctx_total     = fwd_q + CNT_W'(resid_q);
  assign ctx_resid_len = resid_q;

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ctx_load && lim_ovf)
      |=> (req_err && req_ready && $stable(ctx_total)));

  // R2
  short_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q && running) |-> !out_valid);

  // R10
  idle_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && !in_ready));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ctx_load && !lim_ovf) |=> !req_ready);
endmodule

// File: tb/stream_hash_aggregator_tb_top.sv
module stream_hash_aggregator_tb_top;
  logic        clk, rst_n;
  logic        req_valid, req_final, req_ready, req_err;
  logic [31:0] req_len;
  logic        in_valid, in_ready;
  logic [7:0]  in_byte;
  logic        out_valid, out_ready;
  logic [31:0] out_word;
  logic [63:0] ctx_total, ctx_load_total;
  logic [5:0]  ctx_resid_len, ctx_rd_idx, ctx_wr_idx;
  logic [7:0]  ctx_rd_byte, ctx_wr_byte;
  logic        ctx_load, ctx_wr_en;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  mbuf [64];
  int          mlen;
  logic [63:0] mfwd;
  logic [7:0]  dat  [512];
  logic [7:0]  strm [600];
  logic [31:0] exw  [160];
  bit          feed_done;

  stream_hash_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_final(req_final), .req_len(req_len),
    .req_ready(req_ready), .req_err(req_err),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_word(out_word), .out_ready(out_ready),
    .ctx_total(ctx_total), .ctx_resid_len(ctx_resid_len),
    .ctx_rd_idx(ctx_rd_idx), .ctx_rd_byte(ctx_rd_byte),
    .ctx_load(ctx_load), .ctx_load_total(ctx_load_total),
    .ctx_wr_en(ctx_wr_en), .ctx_wr_idx(ctx_wr_idx), .ctx_wr_byte(ctx_wr_byte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check_ctx(input string rq);
    int bad = 0;
    logic [7:0] fa = 0, fe = 0;
    chk(ctx_total == mfwd + 64'(mlen), "R6", "ctx_total", ctx_total, mfwd + 64'(mlen));
    chk(ctx_resid_len == 6'(mlen), rq, "residual length", 64'(ctx_resid_len), 64'(mlen));
    for (int i = 0; i < mlen; i++) begin
      ctx_rd_idx = 6'(i);
      #1;
      if (ctx_rd_byte !== mbuf[i]) begin
        if (bad == 0) begin fa = ctx_rd_byte; fe = mbuf[i]; end
        bad++;
      end
    end
    chk(bad == 0, rq, "residual bytes", 64'(fa), 64'(fe));
  endtask

  task automatic run_req(input bit fin, input int n, input int rdy_pct,
                         input int vld_pct, input string rq);
    int tot, lim, nw, got, bad;
    logic [31:0] fa, fe;
    for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
    for (int i = 0; i < mlen; i++) strm[i] = mbuf[i];
    for (int i = 0; i < n; i++) strm[mlen + i] = dat[i];
    tot = mlen + n;
    lim = fin ? (tot / 4) * 4 : (tot / 64) * 64;
    nw  = lim / 4;
    for (int k = 0; k < nw; k++)
      exw[k] = {strm[4*k+3], strm[4*k+2], strm[4*k+1], strm[4*k]};
    for (int i = 0; i < tot - lim; i++) mbuf[i] = strm[lim + i];
    mlen = tot - lim;
    mfwd = mfwd + 64'(lim);

    @(negedge clk);
    req_valid = 1'b1; req_final = fin; req_len = 32'(n);
    @(negedge clk);
    req_valid = 1'b0;
    feed_done = (n == 0);
    got = 0; bad = 0; fa = 0; fe = 0;
    fork
      begin
        int i = 0;
        while (i < n) begin
          bit hs;
          @(negedge clk);
          in_valid = (($urandom % 100) < vld_pct);
          in_byte  = dat[i];
          #4;
          hs = in_valid && in_ready;
          @(posedge clk);
          if (hs) i++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        feed_done = 1'b1;
      end
      begin
        while (1) begin
          @(negedge clk);
          out_ready = (got >= nw) ? 1'b1 : (($urandom % 100) < rdy_pct);
          #4;
          if (out_valid && out_ready) begin
            if (got < nw && out_word !== exw[got]) begin
              if (bad == 0) begin fa = out_word; fe = exw[got]; end
              bad++;
            end
            got++;
          end
          if (feed_done && req_ready && !out_valid) break;
          @(posedge clk);
        end
        out_ready = 1'b0;
      end
    join
    chk(got == nw, rq, "forwarded word count", 64'(got), 64'(nw));
    chk(bad == 0, {rq, "/R5"}, "word content", 64'(fa), 64'(fe));
    check_ctx(rq);
  endtask

  task automatic restore(input logic [63:0] tot);
    @(negedge clk);
    ctx_load = 1'b1; ctx_load_total = tot;
    @(negedge clk);
    ctx_load = 1'b0;
    mlen = int'(tot[5:0]);
    mfwd = tot & ~64'h3F;
    for (int i = 0; i < mlen; i++) begin
      mbuf[i] = 8'($urandom);
      ctx_wr_en = 1'b1; ctx_wr_idx = 6'(i); ctx_wr_byte = mbuf[i];
      @(negedge clk);
    end
    ctx_wr_en = 1'b0;
    chk(ctx_total == tot, "R7", "restored total", ctx_total, tot);
    check_ctx("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] tot_before;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; req_final = 0; req_len = 0;
    in_valid = 0; in_byte = 0; out_ready = 0; ctx_rd_idx = 0;
    ctx_load = 0; ctx_load_total = 0; ctx_wr_en = 0; ctx_wr_idx = 0; ctx_wr_byte = 0;
    mlen = 0; mfwd = 0; feed_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R10 at reset
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(!out_valid && !in_ready && !req_err, "R1", "out_valid/in_ready/req_err",
        {61'd0, out_valid, in_ready, req_err}, 64'd0);
    chk(ctx_total == 64'd0, "R1", "ctx_total", ctx_total, 64'd0);
    chk(in_ready == 1'b0, "R10", "in_ready idle", 64'(in_ready), 64'd0);

    run_req(1'b0, 60, 100, 100, "R2");
    run_req(1'b0, 60, 50, 70, "R3");
    chk(mlen == 56, "R3", "model residual 60+60", 64'(ctx_resid_len), 64'd56);

    // R8: total reaches exactly 2^32 and is refused
    tot_before = ctx_total;
    @(negedge clk);
    req_valid = 1'b1; req_final = 1'b0; req_len = 32'hFFFF_FFFF - 32'd55;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, "R8", "req_err pulse", 64'(req_err), 64'd1);
    chk(req_ready == 1'b1, "R8", "stays idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(req_err == 1'b0, "R8", "req_err one cycle", 64'(req_err), 64'd0);
    chk(ctx_total == tot_before, "R8", "ctx_total unchanged", ctx_total, tot_before);
    check_ctx("R8");

    run_req(1'b1, 3, 60, 80, "R4");
    run_req(1'b0, 130, 20, 90, "R9");

    restore(64'h0000_0001_0000_0047);
    run_req(1'b0, 57, 70, 70, "R3");
    restore(64'd6);
    run_req(1'b1, 0, 100, 100, "R4");
    restore(64'd0);

    for (int t = 0; t < 30; t++) begin
      bit fin;
      fin = (($urandom % 4) == 0);
      run_req(fin, int'($urandom % 150), 30 + int'($urandom % 71),
              30 + int'($urandom % 71), fin ? "R4" : "R3");
    end
    chk(req_ready && !in_ready, "R10", "idle after stream", {62'd0, req_ready, in_ready}, 64'd2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule